// File: doc/BRIEF.md
# Multi-Region Sector Locator

This block resolves a byte address inside a flash array whose erase sectors are not all the same size. The array is split into as many as four erase regions. Each region holds a configurable number of sectors of one power-of-two size, and the regions follow one another with no gaps, starting at address zero. For each address presented, the block returns the global sector number, the size of that sector and the address where the sector starts. It also returns a flag that shows whether that sector is waiting to be erased.

A command sequencer uses it in two ways. It marks the sector of the current address as erase-pending when it accepts a sector-erase command. It clears every pending mark at once when the erase operation finishes. The block checks the region configuration continuously and reports any layout it cannot resolve. Results are registered, so a lookup costs exactly one clock.

Top module: `slc_sector_locator`

## Requirements
- R1: With `cfg_nregions_i` set to 1 to 4, regions 0 to n-1 are placed back to back from address 0 in index order. Region k is `cfg_count_i[k*8 +: 8]` sectors of `cfg_len_i[k*24 +: 24]` bytes each. Slots at index n or above are ignored.
- R2: With `cfg_nregions_i` set to 0, a single region of `cfg_uni_count_i` sectors of `cfg_uni_len_i` bytes is used, and every per-region slot is ignored.
- R3: For an in-range address, `sect_idx_o` equals the sector counts of all earlier regions added together, plus the offset into the hit region divided by that region's sector length.
- R4: For an in-range address, `sect_len_o` is the sector length of the hit region. `sect_base_o` is the address with every bit below that length cleared.
- R5: Outputs are registered. The address presented at one rising edge is reflected from that edge until the next one. During reset, every output is 0.
- R6: An address at or beyond the summed length of all active regions sets `out_of_range_o`. In that case `sect_idx_o`, `sect_len_o`, `sect_base_o` and `erasing_o` are all 0.
- R7: `cfg_err_o` is set in any of these cases: `cfg_nregions_i` is above 4; an active region's length is not a nonzero power of two; its length has any of bits 7..0 set; its length is 16 MiB or more; its start address is not a multiple of its length; or the active regions hold more than 64 sectors in total. While the error is set, all other outputs are 0 and `mark_i` has no effect.
- R8: `mark_i` sets the pending bit of the sector that the address of the same cycle resolves to. `erasing_o` reports that sector's pending bit as it stood before the edge, so it reads 1 from the following lookup onward.
- R9: `clear_i` empties the whole pending map, and it wins over a `mark_i` in the same cycle.
- R10: `mark_i` with an out-of-range address changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_nregions_i | input | 3 | Number of explicit regions; 0 selects the uniform layout |
| cfg_count_i | input | 32 | Sector count of each region slot, 8 bits per slot |
| cfg_len_i | input | 96 | Sector length in bytes of each region slot, 24 bits per slot |
| cfg_uni_count_i | input | 8 | Sector count of the uniform layout |
| cfg_uni_len_i | input | 24 | Sector length of the uniform layout |
| addr_i | input | 24 | Byte address to resolve |
| mark_i | input | 1 | Mark the resolved sector as erase-pending |
| clear_i | input | 1 | Clear every erase-pending mark |
| sect_idx_o | output | 10 | Global sector number |
| sect_len_o | output | 24 | Sector length in bytes |
| sect_base_o | output | 24 | Start address of the sector |
| erasing_o | output | 1 | The resolved sector is erase-pending |
| out_of_range_o | output | 1 | Address lies beyond the array |
| cfg_err_o | output | 1 | Region configuration cannot be resolved |

## Verification
The lookup is first exercised on a three-region layout with mixed sizes. Addresses are taken at the first and last byte of each region and in the middle of a sector, so an error in a region boundary, in the running sector count or in the size-dependent shift shows up as a wrong index or base. The same lookups on a uniform layout, whose per-region slots hold illegal values, tell whether the mode select really ignores those slots. A four-region layout that fills exactly 64 sectors probes the last bitmap entry and the first address past the end. Broken layouts (misaligned, non-power-of-two, too fine, too many regions, too many sectors) each have to raise the error on their own. The mark sequences check same-cycle visibility, clear priority, and that a mark is dropped when the address is out of range or the configuration is in error.

// File: rtl/slc_pkg.sv
package slc_pkg;

  localparam int unsigned MIN_SECT_BYTES = 256;
  localparam logic [31:0] SECT_LEN_LIMIT = 32'h0100_0000;

  typedef struct packed {
    logic bad_sel;
    logic bad_len;
    logic misaligned;
    logic too_many;
  } cfg_fault_t;

  function automatic logic len_is_legal(input logic [31:0] len);
    logic pow2;
    pow2 = (len != 32'd0) && ((len & (len - 32'd1)) == 32'd0);
    return pow2 && (len[7:0] == 8'd0) && (len < SECT_LEN_LIMIT);
  endfunction

  function automatic logic [5:0] len_lg2(input logic [31:0] len);
    logic [5:0] lg;
    lg = '0;
    for (int b = 0; b < 32; b++) begin
      if (len[b]) lg = 6'(b);
    end
    return lg;
  endfunction

  function automatic logic start_aligned(input logic [63:0] start, input logic [31:0] len);
    return (start & (64'(len) - 64'd1)) == 64'd0;
  endfunction

  function automatic logic [63:0] clear_below(input logic [63:0] a, input logic [31:0] len);
    return a & ~(64'(len) - 64'd1);
  endfunction

endpackage

// File: rtl/slc_region_table.sv
module slc_region_table
  import slc_pkg::*;
#(
  parameter int unsigned NREG     = 4,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LEN_W    = 24,
  parameter int unsigned MAX_SECT = 64,
  parameter int unsigned TOT_W    = 35,
  parameter int unsigned IDX_W    = 10
) (
  input  logic [$clog2(NREG+1)-1:0] cfg_nregions,
  input  logic [NREG*CNT_W-1:0]     cfg_count,
  input  logic [NREG*LEN_W-1:0]     cfg_len,
  input  logic [CNT_W-1:0]          uni_count,
  input  logic [LEN_W-1:0]          uni_len,
  output logic [NREG-1:0]           active_o,
  output logic [TOT_W-1:0]          start_o   [NREG],
  output logic [TOT_W-1:0]          end_o     [NREG],
  output logic [IDX_W-1:0]          base_idx_o[NREG],
  output logic [LEN_W-1:0]          len_o     [NREG],
  output logic [5:0]                lg_o      [NREG],
  output cfg_fault_t                fault_o
);

  localparam int unsigned NSEL_W = $clog2(NREG+1);

  logic                 uniform;
  logic [CNT_W-1:0]     eff_cnt [NREG];
  logic [IDX_W-1:0]     end_idx [NREG];
  logic [NREG-1:0]      bad_len_v;
  logic [NREG-1:0]      misal_v;

  assign uniform = (cfg_nregions == '0);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [CNT_W-1:0] cnt_raw;
    logic [LEN_W-1:0] len_raw;
    logic [TOT_W-1:0] span;

    assign cnt_raw = cfg_count[i*CNT_W +: CNT_W];
    assign len_raw = cfg_len[i*LEN_W +: LEN_W];

    if (i == 0) begin : g_first
      assign eff_cnt[i]    = uniform ? uni_count : cnt_raw;
      assign len_o[i]      = uniform ? uni_len   : len_raw;
      assign active_o[i]   = 1'b1;
      assign start_o[i]    = '0;
      assign base_idx_o[i] = '0;
    end else begin : g_next
      assign eff_cnt[i]    = cnt_raw;
      assign len_o[i]      = len_raw;
      assign active_o[i]   = !uniform && (NSEL_W'(i) < cfg_nregions);
      assign start_o[i]    = end_o[i-1];
      assign base_idx_o[i] = end_idx[i-1];
    end

    assign lg_o[i]    = len_lg2(32'(len_o[i]));
    assign span       = active_o[i] ? (TOT_W'(eff_cnt[i]) << lg_o[i]) : '0;
    assign end_o[i]   = start_o[i] + span;
    assign end_idx[i] = base_idx_o[i] + (active_o[i] ? IDX_W'(eff_cnt[i]) : '0);

    assign bad_len_v[i] = active_o[i] && !len_is_legal(32'(len_o[i]));
    assign misal_v[i]   = active_o[i] && !start_aligned(64'(start_o[i]), 32'(len_o[i]));
  end

  assign fault_o.bad_sel    = cfg_nregions > NSEL_W'(NREG);
  assign fault_o.bad_len    = |bad_len_v;
  assign fault_o.misaligned = |misal_v;
  assign fault_o.too_many   = end_idx[NREG-1] > IDX_W'(MAX_SECT);

endmodule

// File: rtl/slc_match.sv
module slc_match
  import slc_pkg::*;
#(
  parameter int unsigned NREG   = 4,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 24,
  parameter int unsigned TOT_W  = 35,
  parameter int unsigned IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NREG-1:0]   active,
  input  logic [TOT_W-1:0]  start_i   [NREG],
  input  logic [TOT_W-1:0]  end_i     [NREG],
  input  logic [IDX_W-1:0]  base_idx_i[NREG],
  input  logic [LEN_W-1:0]  len_i     [NREG],
  input  logic [5:0]        lg_i      [NREG],
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [ADDR_W-1:0] base_o
);

  logic [TOT_W-1:0] addr_w;
  logic [NREG-1:0]  hit_v;
  logic [IDX_W-1:0] local_idx [NREG];

  assign addr_w = TOT_W'(addr);

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign hit_v[i]     = active[i] && (addr_w >= start_i[i]) && (addr_w < end_i[i]);
    assign local_idx[i] = IDX_W'((addr_w - start_i[i]) >> lg_i[i]);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    len_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        hit_o = 1'b1;
        idx_o = base_idx_i[i] + local_idx[i];
        len_o = len_i[i];
      end
    end
  end

  assign base_o = ADDR_W'(clear_below(64'(addr), 32'(len_o)));

endmodule

// File: rtl/slc_pend_map.sv
module slc_pend_map #(
  parameter int unsigned MAX_SECT = 64,
  parameter int unsigned IDX_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                clr,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_bit,
  output logic [MAX_SECT-1:0] map_o
);

  localparam int unsigned MAP_AW = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1;

  for (genvar i = 0; i < MAX_SECT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                   map_o[i] <= 1'b0;
      else if (clr)                                 map_o[i] <= 1'b0;
      else if (set_en && (set_idx == IDX_W'(i)))    map_o[i] <= 1'b1;
    end
  end

  assign rd_bit = (rd_idx < IDX_W'(MAX_SECT)) ? map_o[rd_idx[MAP_AW-1:0]] : 1'b0;

endmodule

// File: rtl/slc_sector_locator.sv
module slc_sector_locator
  import slc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned NREG     = 4,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LEN_W    = 24,
  parameter int unsigned MAX_SECT = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [$clog2(NREG+1)-1:0]         cfg_nregions_i,
  input  logic [NREG*CNT_W-1:0]             cfg_count_i,
  input  logic [NREG*LEN_W-1:0]             cfg_len_i,
  input  logic [CNT_W-1:0]                  cfg_uni_count_i,
  input  logic [LEN_W-1:0]                  cfg_uni_len_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              mark_i,
  input  logic                              clear_i,
  output logic [CNT_W+$clog2(NREG)-1:0]     sect_idx_o,
  output logic [LEN_W-1:0]                  sect_len_o,
  output logic [ADDR_W-1:0]                 sect_base_o,
  output logic                              erasing_o,
  output logic                              out_of_range_o,
  output logic                              cfg_err_o
);

  localparam int unsigned IDX_W = CNT_W + $clog2(NREG);
  localparam int unsigned TOT_W = LEN_W + CNT_W + $clog2(NREG) + 1;

  logic [NREG-1:0]  rg_active;
  logic [TOT_W-1:0] rg_start   [NREG];
  logic [TOT_W-1:0] rg_end     [NREG];
  logic [IDX_W-1:0] rg_base_idx[NREG];
  logic [LEN_W-1:0] rg_len     [NREG];
  logic [5:0]       rg_lg      [NREG];
  cfg_fault_t       fault;

  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;
  logic [LEN_W-1:0]  lk_len;
  logic [ADDR_W-1:0] lk_base;

  logic                cfg_bad;
  logic                lk_valid;
  logic                mark_accept;
  logic                pend_rd;
  logic [MAX_SECT-1:0] pend_map;

  slc_region_table #(
    .NREG(NREG), .CNT_W(CNT_W), .LEN_W(LEN_W),
    .MAX_SECT(MAX_SECT), .TOT_W(TOT_W), .IDX_W(IDX_W)
  ) u_table (
    .cfg_nregions (cfg_nregions_i),
    .cfg_count    (cfg_count_i),
    .cfg_len      (cfg_len_i),
    .uni_count    (cfg_uni_count_i),
    .uni_len      (cfg_uni_len_i),
    .active_o     (rg_active),
    .start_o      (rg_start),
    .end_o        (rg_end),
    .base_idx_o   (rg_base_idx),
    .len_o        (rg_len),
    .lg_o         (rg_lg),
    .fault_o      (fault)
  );

  slc_match #(
    .NREG(NREG), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TOT_W(TOT_W), .IDX_W(IDX_W)
  ) u_match (
    .addr       (addr_i),
    .active     (rg_active),
    .start_i    (rg_start),
    .end_i      (rg_end),
    .base_idx_i (rg_base_idx),
    .len_i      (rg_len),
    .lg_i       (rg_lg),
    .hit_o      (lk_hit),
    .idx_o      (lk_idx),
    .len_o      (lk_len),
    .base_o     (lk_base)
  );

  assign cfg_bad     = |fault;
  assign lk_valid    = lk_hit && !cfg_bad;
  assign mark_accept = mark_i && lk_valid;

  slc_pend_map #(
    .MAX_SECT(MAX_SECT), .IDX_W(IDX_W)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (mark_accept),
    .set_idx (lk_idx),
    .clr     (clear_i),
    .rd_idx  (lk_idx),
    .rd_bit  (pend_rd),
    .map_o   (pend_map)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sect_idx_o     <= '0;
      sect_len_o     <= '0;
      sect_base_o    <= '0;
      erasing_o      <= 1'b0;
      out_of_range_o <= 1'b0;
      cfg_err_o      <= 1'b0;
    end else begin
      cfg_err_o      <= cfg_bad;
      out_of_range_o <= !cfg_bad && !lk_hit;
      sect_idx_o     <= lk_valid ? lk_idx  : '0;
      sect_len_o     <= lk_valid ? lk_len  : '0;
      sect_base_o    <= lk_valid ? lk_base : '0;
      erasing_o      <= lk_valid && pend_rd;
    end
  end

endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned LEN_W    = 24,
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned MAX_SECT = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                clear_i,
  input logic [IDX_W-1:0]    sect_idx_o,
  input logic [LEN_W-1:0]    sect_len_o,
  input logic [ADDR_W-1:0]   sect_base_o,
  input logic                erasing_o,
  input logic                out_of_range_o,
  input logic                cfg_err_o,
  input logic                mark_accept,
  input logic [MAX_SECT-1:0] pend_map
);

  logic primed;
  logic good;

  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assign good = primed && !out_of_range_o && !cfg_err_o;

  assert_cfg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (sect_len_o == '0) && !erasing_o && !out_of_range_o);

  assert_oor_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range_o |-> (sect_len_o == '0) && (sect_idx_o == '0) && !erasing_o);

  assert_len_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    good |-> $countones(sect_len_o) == 1);

  assert_base_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    good |-> (sect_base_o & (ADDR_W'(sect_len_o) - ADDR_W'(1))) == '0);

  assert_base_follows_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    good |-> sect_base_o == ($past(addr_i) & ~(ADDR_W'(sect_len_o) - ADDR_W'(1))));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> pend_map == '0);

  assert_mark_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mark_accept && !clear_i |=> pend_map != '0);

  assert_map_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_accept && !clear_i |=> $stable(pend_map));

endmodule

bind slc_sector_locator slc_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .MAX_SECT(MAX_SECT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .addr_i         (addr_i),
  .clear_i        (clear_i),
  .sect_idx_o     (sect_idx_o),
  .sect_len_o     (sect_len_o),
  .sect_base_o    (sect_base_o),
  .erasing_o      (erasing_o),
  .out_of_range_o (out_of_range_o),
  .cfg_err_o      (cfg_err_o),
  .mark_accept    (mark_accept),
  .pend_map       (pend_map)
);

// File: tb/tb_slc_sector_locator.sv
module tb_slc_sector_locator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_nregions_i = '0;
  logic [31:0] cfg_count_i = '0;
  logic [95:0] cfg_len_i = '0;
  logic [7:0]  cfg_uni_count_i = '0;
  logic [23:0] cfg_uni_len_i = '0;
  logic [23:0] addr_i = '0;
  logic        mark_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [9:0]  sect_idx_o;
  logic [23:0] sect_len_o;
  logic [23:0] sect_base_o;
  logic        erasing_o;
  logic        out_of_range_o;
  logic        cfg_err_o;

  always #4 clk = ~clk;

  slc_sector_locator dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_nregions_i(cfg_nregions_i), .cfg_count_i(cfg_count_i), .cfg_len_i(cfg_len_i),
    .cfg_uni_count_i(cfg_uni_count_i), .cfg_uni_len_i(cfg_uni_len_i),
    .addr_i(addr_i), .mark_i(mark_i), .clear_i(clear_i),
    .sect_idx_o(sect_idx_o), .sect_len_o(sect_len_o), .sect_base_o(sect_base_o),
    .erasing_o(erasing_o), .out_of_range_o(out_of_range_o), .cfg_err_o(cfg_err_o)
  );

  typedef struct {
    string  tag;
    longint addr;
    bit     err;
    bit     oor;
    bit     ers;
    longint idx;
    longint len;
    longint base;
  } exp_t;

  exp_t    q[$];
  exp_t    mon_e;
  int      n_run = 0;
  int      n_fail = 0;
  int      m_nreg;
  longint  m_cnt[4];
  longint  m_len[4];
  longint  m_ucnt;
  longint  m_ulen;
  bit [63:0] m_map;

  // Independent model: walks every sector in turn.
  function automatic exp_t model(longint a);
    exp_t   e;
    int     nr;
    longint c, l;
    longint pos = 0;
    longint sidx = 0;
    bit     bad = 0;
    bit     found = 0;
    e.tag = ""; e.addr = a; e.err = 0; e.oor = 0; e.ers = 0;
    e.idx = 0; e.len = 0; e.base = 0;
    if (m_nreg > 4) bad = 1;
    nr = (m_nreg == 0) ? 1 : ((m_nreg > 4) ? 4 : m_nreg);
    for (int k = 0; k < nr; k++) begin
      c = (m_nreg == 0) ? m_ucnt : m_cnt[k];
      l = (m_nreg == 0) ? m_ulen : m_len[k];
      if (l <= 0 || (l & (l - 1)) != 0 || (l % 256) != 0 || l >= 64'h100_0000) bad = 1;
      else if ((pos % l) != 0) bad = 1;
      for (longint s = 0; s < c; s++) begin
        if (!found && a >= pos && a < pos + l) begin
          found = 1; e.idx = sidx; e.len = l; e.base = pos;
        end
        pos += l;
        sidx++;
      end
    end
    if (sidx > 64) bad = 1;
    if (bad) begin
      e.err = 1; e.idx = 0; e.len = 0; e.base = 0;
    end else if (!found) begin
      e.oor = 1;
    end
    return e;
  endfunction

  task automatic apply_cfg(int nr, longint c0, longint l0, longint c1, longint l1,
                           longint c2, longint l2, longint c3, longint l3,
                           longint uc, longint ul);
    @(negedge clk);
    m_nreg = nr;
    m_cnt[0] = c0; m_cnt[1] = c1; m_cnt[2] = c2; m_cnt[3] = c3;
    m_len[0] = l0; m_len[1] = l1; m_len[2] = l2; m_len[3] = l3;
    m_ucnt = uc; m_ulen = ul;
    cfg_nregions_i = 3'(nr);
    for (int k = 0; k < 4; k++) begin
      cfg_count_i[k*8 +: 8]  = 8'(m_cnt[k]);
      cfg_len_i[k*24 +: 24]  = 24'(m_len[k]);
    end
    cfg_uni_count_i = 8'(uc);
    cfg_uni_len_i   = 24'(ul);
    mark_i = 1'b0;
    clear_i = 1'b0;
  endtask

  // Driver: presents one lookup and queues the result it must produce.
  task automatic drive(longint a, bit mk, bit cl, string tag);
    exp_t e;
    @(negedge clk);
    addr_i = 24'(a); mark_i = mk; clear_i = cl;
    e = model(a);
    e.tag = tag;
    if (!e.err && !e.oor) e.ers = m_map[e.idx];
    q.push_back(e);
    if (cl) m_map = '0;
    else if (mk && !e.err && !e.oor) m_map[e.idx] = 1'b1;
  endtask

  // Monitor: compares one registered result after each rising edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      n_run++;
      if (cfg_err_o !== mon_e.err || out_of_range_o !== mon_e.oor || erasing_o !== mon_e.ers ||
          longint'(sect_idx_o) != mon_e.idx || longint'(sect_len_o) != mon_e.len ||
          longint'(sect_base_o) != mon_e.base) begin
        n_fail++;
        $display("FAIL %s addr=%h got idx=%0d len=%h base=%h ers=%0b oor=%0b err=%0b expected idx=%0d len=%h base=%h ers=%0b oor=%0b err=%0b",
                 mon_e.tag, mon_e.addr, sect_idx_o, sect_len_o, sect_base_o, erasing_o,
                 out_of_range_o, cfg_err_o, mon_e.idx, mon_e.len, mon_e.base, mon_e.ers,
                 mon_e.oor, mon_e.err);
      end
    end
  end

  task automatic cfg_a();
    // three regions: 4x4K, 2x16K, 3x8K; slot 3 holds junk
    apply_cfg(3, 4, 'h1000, 2, 'h4000, 3, 'h2000, 7, 'h123, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_map = '0;
    cfg_a();
    repeat (3) @(negedge clk);
    n_run++;
    if (sect_idx_o !== '0 || sect_len_o !== '0 || sect_base_o !== '0 ||
        erasing_o !== 1'b0 || out_of_range_o !== 1'b0 || cfg_err_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R5 reset: got idx=%0d len=%h base=%h flags=%b%b%b expected all zero",
               sect_idx_o, sect_len_o, sect_base_o, erasing_o, out_of_range_o, cfg_err_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R3 R4: region edges and mid-sector addresses
    drive('h0,     0, 0, "R1 R3 first byte");
    drive('h0FFF,  0, 0, "R3 end of sector 0");
    drive('h1234,  0, 0, "R4 mid sector");
    drive('h3FFF,  0, 0, "R1 end of region 0");
    drive('h4000,  0, 0, "R1 start of region 1");
    drive('h7FFF,  0, 0, "R4 last byte of 16K sector");
    drive('h8000,  0, 0, "R3 second 16K sector");
    drive('hC000,  0, 0, "R1 start of region 2");
    drive('h11FFF, 0, 0, "R3 R4 last byte of array");
    drive('h12000, 0, 0, "R6 first byte past end");
    drive('hFFFFFF,0, 0, "R6 top address");

    // R8 marking and visibility
    drive('h5000, 1, 0, "R8 mark sees old bit");
    drive('h4000, 0, 0, "R8 marked sector reads pending");
    drive('h7FFF, 0, 0, "R8 same sector other byte");
    drive('hD000, 1, 0, "R8 second mark");
    drive('hC000, 0, 0, "R8 second mark visible");
    drive('h8000, 0, 0, "R8 neighbour untouched");
    // R10 out-of-range mark, then scan every sector
    drive('h20000, 1, 0, "R10 mark out of range");
    drive('h0,     0, 0, "R10 scan");
    drive('h1000,  0, 0, "R10 scan");
    drive('h2000,  0, 0, "R10 scan");
    drive('h3000,  0, 0, "R10 scan");
    drive('hE000,  0, 0, "R10 scan");
    drive('h10000, 0, 0, "R10 scan");
    // R9 clear wins over mark
    drive('h0,    1, 1, "R9 clear with mark");
    drive('h0,    0, 0, "R9 mark dropped by clear");
    drive('h4000, 0, 0, "R9 map empty");
    drive('hC000, 0, 0, "R9 map empty");

    // R2 uniform layout, junk in the slots
    apply_cfg(0, 5, 'h1800, 9, 'h80, 1, 'h1, 2, 'h3, 16, 'h10000);
    drive('h0ABCDE, 0, 0, "R2 uniform mid");
    drive('h0FFFFF, 0, 0, "R2 uniform last byte");
    drive('h100000, 0, 0, "R2 R6 uniform past end");

    // R7 configuration faults
    apply_cfg(2, 1, 'h1000, 1, 'h2000, 0, 0, 0, 0, 0, 0);
    drive('h0, 1, 0, "R7 misaligned start, mark ignored");
    cfg_a();
    drive('h0, 0, 0, "R7 mark under error left no bit");
    apply_cfg(1, 2, 'h1800, 0, 0, 0, 0, 0, 0, 0, 0);
    drive('h0, 0, 0, "R7 length not power of two");
    apply_cfg(1, 2, 'h80, 0, 0, 0, 0, 0, 0, 0, 0);
    drive('h0, 0, 0, "R7 length below 256");
    apply_cfg(5, 1, 'h1000, 1, 'h1000, 1, 'h1000, 1, 'h1000, 0, 0);
    drive('h0, 0, 0, "R7 too many regions");
    apply_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 65, 'h100);
    drive('h0, 0, 0, "R7 more than 64 sectors");
    apply_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 64, 'h100);
    drive('h3FFF, 0, 0, "R7 exactly 64 sectors accepted");

    // R1 four regions filling all 64 sectors
    apply_cfg(4, 16, 'h100, 16, 'h100, 16, 'h100, 16, 'h100, 0, 0);
    drive('h3F00, 1, 0, "R8 mark last bitmap entry");
    drive('h3FFF, 0, 0, "R8 last entry pending");
    drive('h2F80, 0, 0, "R1 region 2");
    drive('h4000, 0, 0, "R6 past four regions");
    drive('h0,    0, 1, "R9 clear");
    drive('h3F00, 0, 0, "R9 last entry cleared");

    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule